// File: doc/BRIEF.md
# Packet Hardware Timestamp Unit

This block keeps a free-running local time value in nanoseconds and freezes a copy of it when a timing message crosses the port. The transmit side and the receive side each give a one-cycle start-of-message strobe with a one-bit message kind (synchronisation or delay request). Each direction and kind pair has its own capture slot, so one outgoing and one incoming event in the same cycle are both kept. Software fetches each frozen value later through a simple register port.

Software also writes the master-slave time difference and the two timestamps that the far end reported. From these values and the locally captured stamps, the block forms the master-to-slave and slave-to-master one-way path delays as signed results that software can read.

All registers are 64 bits wide and sit behind a 4-bit word address. Read data is combinational from the address. A read strobe has a side effect only on the stamp addresses.

Top module: `ts_stamp_unit`

## Requirements
- R1: After reset the time value is 0 and the increment is 8. On every clock edge that does not load the time, the time value grows by the increment. Address 0 reads the time value and address 1 reads the increment.
- R2: A write to address 1 replaces the increment. From the next edge on, the time value grows by the new amount.
- R3: A write to address 0 sets the time value to the written data at that clock edge. A capture on the same edge stores the time value as it was before the load.
- R4: A transmit strobe captures the current time value into the transmit slot for its kind, and a receive strobe into the receive slot for its kind. Kind 0 is sync and kind 1 is delay request. The slots read at address 2 (tx sync), 3 (tx delay request), 4 (rx sync) and 5 (rx delay request). Coincident transmit and receive events are both captured.
- R5: Address 6 is the status word. Bits 3:0 are the valid flags of slots 2..5 and bits 7:4 are their overrun flags. All other bits are 0. A capture sets a valid flag. A read strobe on the slot's address clears it. After reset all flags are 0.
- R6: A strobe that arrives while its slot is valid and not being read keeps the old stamp and sets that slot's overrun flag. The overrun flag stays set.
- R7: Writing a 1 to status bit 4+i clears overrun flag i. Writing a 0 leaves it unchanged, and the valid flags are not affected.
- R8: The master-to-slave delay at address 10 equals rx sync stamp + offset (address 7) − remote departure stamp (address 8), as a signed 64-bit value.
- R9: The slave-to-master delay at address 11 equals remote arrival stamp (address 9) − (tx delay-request stamp + offset), as a signed 64-bit value and possibly negative.
- R10: Each delay result changes only on the edge one cycle after a write to its remote stamp register (address 8 or 9). A write to the offset alone does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_sof | input | 1 | Message departure strobe |
| tx_kind | input | 1 | Departing message kind (0 sync, 1 delay request) |
| rx_sof | input | 1 | Message arrival strobe |
| rx_kind | input | 1 | Arriving message kind (0 sync, 1 delay request) |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears a stamp's valid flag) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational from reg_addr |

## Verification
The bench loads the time and fires a capture on the same edge. A design that lets the load win would return the loaded value instead of the earlier count. It repeats a strobe into a full slot. The wrong behaviours there are overwriting the stamp or dropping the overrun flag. It also writes zeros to the status word, which a careless clear path would treat as a clear. On the delay side, the bench checks that a result holds its old value for the cycle after the remote write and only then changes. It checks that an offset-only write leaves the result alone, and it drives the slave-to-master delay negative to expose sign handling. A long random run against a reference model then mixes coincident events, reads that clear in the same cycle as a new strobe, and register writes.

// File: rtl/ts_pkg.sv
package ts_pkg;
    localparam int TIME_W    = 64;
    localparam int ADDR_W    = 4;
    localparam int N_SLOT    = 4;
    localparam int SLOT_BASE = 2;

    typedef logic [TIME_W-1:0]        tstamp_t;
    typedef logic signed [TIME_W-1:0] tdelta_t;

    typedef enum logic { KIND_SYNC = 1'b0, KIND_DREQ = 1'b1 } msg_kind_e;

    typedef enum logic [ADDR_W-1:0] {
        A_TIME    = 4'd0,
        A_INC     = 4'd1,
        A_TX_SYNC = 4'd2,
        A_TX_DREQ = 4'd3,
        A_RX_SYNC = 4'd4,
        A_RX_DREQ = 4'd5,
        A_STATUS  = 4'd6,
        A_OFFSET  = 4'd7,
        A_PEER_TX = 4'd8,
        A_PEER_RX = 4'd9,
        A_M2S     = 4'd10,
        A_S2M     = 4'd11
    } reg_addr_e;

    // slot order: tx sync, tx delay request, rx sync, rx delay request
    function automatic int slot_of(input logic is_rx, input logic kind);
        return 2 * int'(is_rx) + int'(kind);
    endfunction

    function automatic tstamp_t status_word(input logic [N_SLOT-1:0] vld,
                                            input logic [N_SLOT-1:0] ovf);
        return tstamp_t'({ovf, vld});
    endfunction
endpackage

// File: rtl/ts_time_counter.sv
module ts_time_counter import ts_pkg::*; #(
    parameter tstamp_t INC_RESET = tstamp_t'(8)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    load_en,
    input  tstamp_t load_val,
    input  logic    inc_we,
    input  tstamp_t inc_val,
    output tstamp_t now,
    output tstamp_t inc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            now <= '0;
            inc <= INC_RESET;
        end else begin
            if (load_en) now <= load_val;
            else         now <= now + inc;
            if (inc_we)  inc <= inc_val;
        end
    end

    assert_time_advance_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load_en)) |-> (now - $past(now) == $past(inc)));

    assert_time_load_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load_en)) |-> (now == $past(load_val)));

    assert_inc_write_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(inc_we)) |-> (inc == $past(inc_val)));
endmodule

// File: rtl/ts_capture_slot.sv
module ts_capture_slot import ts_pkg::*; (
    input  logic    clk,
    input  logic    rst,
    input  logic    strobe,
    input  tstamp_t now,
    input  logic    rd_clr,
    input  logic    ovf_clr,
    output tstamp_t stamp,
    output logic    valid,
    output logic    ovf
);
    logic busy;
    assign busy = valid && !rd_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            stamp <= '0;
            valid <= 1'b0;
            ovf   <= 1'b0;
        end else begin
            if (strobe && !busy) begin
                stamp <= now;
                valid <= 1'b1;
            end else if (rd_clr) begin
                valid <= 1'b0;
            end
            if (strobe && busy) ovf <= 1'b1;
            else if (ovf_clr)   ovf <= 1'b0;
        end
    end

    assert_valid_on_capture_R5: assert property (@(posedge clk) disable iff (rst)
        strobe |=> valid);

    assert_keep_old_stamp_R6: assert property (@(posedge clk) disable iff (rst)
        (valid && !rd_clr && strobe) |=> ($stable(stamp) && ovf));

    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/ts_delay_calc.sv
module ts_delay_calc import ts_pkg::*; (
    input  logic    clk,
    input  logic    rst,
    input  logic    m2s_go,
    input  logic    s2m_go,
    input  tstamp_t rx_sync,
    input  tstamp_t tx_dreq,
    input  tstamp_t offset,
    input  tstamp_t peer_tx,
    input  tstamp_t peer_rx,
    output tdelta_t m2s,
    output tdelta_t s2m
);
    always_ff @(posedge clk) begin
        if (rst) begin
            m2s <= '0;
            s2m <= '0;
        end else begin
            if (m2s_go) m2s <= tdelta_t'(rx_sync + offset - peer_tx);
            if (s2m_go) s2m <= tdelta_t'(peer_rx - (tx_dreq + offset));
        end
    end

    assert_m2s_value_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(m2s_go)) |->
        (tstamp_t'(m2s) + $past(peer_tx) == $past(rx_sync) + $past(offset)));

    assert_s2m_value_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(s2m_go)) |->
        (tstamp_t'(s2m) + $past(tx_dreq) + $past(offset) == $past(peer_rx)));

    assert_delay_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(m2s_go) && !$past(s2m_go)) |->
        ($stable(m2s) && $stable(s2m)));
endmodule

// File: rtl/ts_stamp_unit.sv
module ts_stamp_unit import ts_pkg::*; #(
    parameter tstamp_t INC_RESET = tstamp_t'(8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_sof,
    input  logic              tx_kind,
    input  logic              rx_sof,
    input  logic              rx_kind,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [TIME_W-1:0] reg_wdata,
    output logic [TIME_W-1:0] reg_rdata
);
    logic wr_time, wr_inc, wr_status, wr_offset, wr_peer_tx, wr_peer_rx;
    assign wr_time    = reg_we && (reg_addr == A_TIME);
    assign wr_inc     = reg_we && (reg_addr == A_INC);
    assign wr_status  = reg_we && (reg_addr == A_STATUS);
    assign wr_offset  = reg_we && (reg_addr == A_OFFSET);
    assign wr_peer_tx = reg_we && (reg_addr == A_PEER_TX);
    assign wr_peer_rx = reg_we && (reg_addr == A_PEER_RX);

    tstamp_t now, inc;

    ts_time_counter #(.INC_RESET(INC_RESET)) u_clock (
        .clk      (clk),
        .rst      (rst),
        .load_en  (wr_time),
        .load_val (reg_wdata),
        .inc_we   (wr_inc),
        .inc_val  (reg_wdata),
        .now      (now),
        .inc      (inc)
    );

    logic [N_SLOT-1:0] strobe, rd_clr, ovf_clr, vld, ovf;
    tstamp_t           stamp [N_SLOT];

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        assign strobe[g]  = (tx_sof && (g == slot_of(1'b0, tx_kind))) ||
                            (rx_sof && (g == slot_of(1'b1, rx_kind)));
        assign rd_clr[g]  = reg_re && (reg_addr == ADDR_W'(SLOT_BASE + g));
        assign ovf_clr[g] = wr_status && reg_wdata[N_SLOT + g];

        ts_capture_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .strobe  (strobe[g]),
            .now     (now),
            .rd_clr  (rd_clr[g]),
            .ovf_clr (ovf_clr[g]),
            .stamp   (stamp[g]),
            .valid   (vld[g]),
            .ovf     (ovf[g])
        );
    end

    tstamp_t offset, peer_tx, peer_rx;
    logic    m2s_go, s2m_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            offset  <= '0;
            peer_tx <= '0;
            peer_rx <= '0;
            m2s_go  <= 1'b0;
            s2m_go  <= 1'b0;
        end else begin
            if (wr_offset)  offset  <= reg_wdata;
            if (wr_peer_tx) peer_tx <= reg_wdata;
            if (wr_peer_rx) peer_rx <= reg_wdata;
            m2s_go <= wr_peer_tx;
            s2m_go <= wr_peer_rx;
        end
    end

    tdelta_t m2s, s2m;

    ts_delay_calc u_delay (
        .clk     (clk),
        .rst     (rst),
        .m2s_go  (m2s_go),
        .s2m_go  (s2m_go),
        .rx_sync (stamp[slot_of(1'b1, KIND_SYNC)]),
        .tx_dreq (stamp[slot_of(1'b0, KIND_DREQ)]),
        .offset  (offset),
        .peer_tx (peer_tx),
        .peer_rx (peer_rx),
        .m2s     (m2s),
        .s2m     (s2m)
    );

    always_comb begin
        case (reg_addr)
            A_TIME:    reg_rdata = now;
            A_INC:     reg_rdata = inc;
            A_TX_SYNC: reg_rdata = stamp[0];
            A_TX_DREQ: reg_rdata = stamp[1];
            A_RX_SYNC: reg_rdata = stamp[2];
            A_RX_DREQ: reg_rdata = stamp[3];
            A_STATUS:  reg_rdata = status_word(vld, ovf);
            A_OFFSET:  reg_rdata = offset;
            A_PEER_TX: reg_rdata = peer_tx;
            A_PEER_RX: reg_rdata = peer_rx;
            A_M2S:     reg_rdata = tstamp_t'(m2s);
            A_S2M:     reg_rdata = tstamp_t'(s2m);
            default:   reg_rdata = '0;
        endcase
    end

    assert_coincident_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_sof && rx_sof) |=> ($countones(vld) >= 2));
endmodule

// File: tb/ts_stamp_unit_test.sv
`timescale 1ns/1ps
module ts_stamp_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_sof = 1'b0, tx_kind = 1'b0, rx_sof = 1'b0, rx_kind = 1'b0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [63:0] reg_wdata = 64'd0;
    logic [63:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ts_stamp_unit uut (
        .clk(clk), .rst(rst), .tx_sof(tx_sof), .tx_kind(tx_kind),
        .rx_sof(rx_sof), .rx_kind(rx_kind), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // reference model built from the requirements
    logic [63:0] m_time, m_inc, m_off, m_ptx, m_prx, m_m2s, m_s2m;
    logic [63:0] m_stamp [4];
    logic [3:0]  m_valid, m_ovf;
    logic        m_go_a, m_go_b;

    always @(posedge clk) begin
        if (rst) begin
            m_time <= 64'd0; m_inc <= 64'd8; m_off <= 64'd0;
            m_ptx <= 64'd0; m_prx <= 64'd0; m_m2s <= 64'd0; m_s2m <= 64'd0;
            m_valid <= 4'd0; m_ovf <= 4'd0; m_go_a <= 1'b0; m_go_b <= 1'b0;
            for (int i = 0; i < 4; i++) m_stamp[i] <= 64'd0;
        end else begin
            m_time <= (reg_we && reg_addr == 4'd0) ? reg_wdata : m_time + m_inc;
            if (reg_we && reg_addr == 4'd1) m_inc <= reg_wdata;
            if (reg_we && reg_addr == 4'd7) m_off <= reg_wdata;
            if (reg_we && reg_addr == 4'd8) m_ptx <= reg_wdata;
            if (reg_we && reg_addr == 4'd9) m_prx <= reg_wdata;
            m_go_a <= reg_we && reg_addr == 4'd8;
            m_go_b <= reg_we && reg_addr == 4'd9;
            if (m_go_a) m_m2s <= m_stamp[2] + m_off - m_ptx;
            if (m_go_b) m_s2m <= m_prx - (m_stamp[1] + m_off);
            for (int i = 0; i < 4; i++) begin
                automatic bit hit  = (tx_sof && i == {1'b0, tx_kind}) ||
                                     (rx_sof && i == {1'b1, rx_kind});
                automatic bit rd   = reg_re && (reg_addr == 4'(i + 2));
                automatic bit full = m_valid[i] && !rd;
                if (hit && !full) begin
                    m_stamp[i] <= m_time;
                    m_valid[i] <= 1'b1;
                end else if (rd) m_valid[i] <= 1'b0;
                if (hit && full) m_ovf[i] <= 1'b1;
                else if (reg_we && reg_addr == 4'd6 && reg_wdata[4 + i]) m_ovf[i] <= 1'b0;
            end
        end
    end

    function automatic logic [63:0] model_read(input logic [3:0] a);
        case (a)
            4'd0: return m_time;
            4'd1: return m_inc;
            4'd2: return m_stamp[0];
            4'd3: return m_stamp[1];
            4'd4: return m_stamp[2];
            4'd5: return m_stamp[3];
            4'd6: return {56'd0, m_ovf, m_valid};
            4'd7: return m_off;
            4'd8: return m_ptx;
            4'd9: return m_prx;
            4'd10: return m_m2s;
            4'd11: return m_s2m;
            default: return 64'd0;
        endcase
    endfunction

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_clear(input logic [3:0] a);
        reg_re = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] ta, t0, tA, tS, tR;
        void'($urandom(32'd1588));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        reg_addr = 4'd6; #1 check(reg_rdata, 64'd0, "R5 reset status");
        reg_addr = 4'd1; #1 check(reg_rdata, 64'd8, "R1 reset increment");
        reg_addr = 4'd0; #1 check(reg_rdata, 64'd0, "R1 reset time");
        @(negedge clk); #1 check(reg_rdata, 64'd8, "R1 advance by increment");

        wr(4'd1, 64'd5);
        reg_addr = 4'd0; #1 ta = reg_rdata;
        @(negedge clk); #1 check(reg_rdata, ta + 64'd5, "R2 new increment");

        // load and capture on the same edge
        t0 = reg_rdata;
        reg_we = 1'b1; reg_wdata = 64'd5000; tx_sof = 1'b1; tx_kind = 1'b0;
        @(negedge clk);
        reg_we = 1'b0; tx_sof = 1'b0;
        #1 check(reg_rdata, 64'd5000, "R3 time load");
        reg_addr = 4'd2; #1 check(reg_rdata, t0, "R3 capture sees pre-load time");
        reg_addr = 4'd6; #1 check(reg_rdata, 64'h01, "R5 valid set");
        rd_clear(4'd2);
        reg_addr = 4'd6; #1 check(reg_rdata, 64'h00, "R5 valid cleared by read");

        // overrun
        reg_addr = 4'd0; #1 tA = reg_rdata;
        tx_sof = 1'b1; tx_kind = 1'b1;
        @(negedge clk);
        @(negedge clk);
        tx_sof = 1'b0;
        reg_addr = 4'd3; #1 check(reg_rdata, tA, "R6 old stamp kept");
        reg_addr = 4'd6; #1 check(reg_rdata, 64'h22, "R6 overrun set");
        wr(4'd6, 64'h0);
        reg_addr = 4'd6; #1 check(reg_rdata, 64'h22, "R7 zero write keeps overrun");
        wr(4'd6, 64'h20);
        reg_addr = 4'd6; #1 check(reg_rdata, 64'h02, "R7 overrun cleared, valid kept");
        rd_clear(4'd3);

        // coincident tx and rx sync
        reg_addr = 4'd0; #1 tS = reg_rdata;
        tx_sof = 1'b1; tx_kind = 1'b0; rx_sof = 1'b1; rx_kind = 1'b0;
        @(negedge clk);
        tx_sof = 1'b0; rx_sof = 1'b0;
        reg_addr = 4'd2; #1 check(reg_rdata, tS, "R4 tx sync stamp");
        reg_addr = 4'd4; #1 check(reg_rdata, tS, "R4 rx sync stamp");
        reg_addr = 4'd6; #1 check(reg_rdata, 64'h05, "R4 both slots valid");
        rd_clear(4'd2);
        rd_clear(4'd4);

        reg_addr = 4'd0; #1 tR = reg_rdata;
        rx_sof = 1'b1; rx_kind = 1'b1;
        @(negedge clk);
        rx_sof = 1'b0;
        reg_addr = 4'd5; #1 check(reg_rdata, tR, "R4 rx delay-request stamp");
        rd_clear(4'd5);

        // master-to-slave delay
        wr(4'd0, 64'd10000);
        rx_sof = 1'b1; rx_kind = 1'b0;
        @(negedge clk);
        rx_sof = 1'b0;
        wr(4'd7, -64'd300);
        wr(4'd8, 64'd9500);
        reg_addr = 4'd10; #1 check(reg_rdata, 64'd0, "R10 m2s not updated yet");
        @(negedge clk); #1 check(reg_rdata, 64'd200, "R8 m2s delay");
        wr(4'd7, 64'd0);
        reg_addr = 4'd10;
        @(negedge clk); #1 check(reg_rdata, 64'd200, "R10 offset write alone");
        wr(4'd7, -64'd300);

        // slave-to-master delay
        wr(4'd0, 64'd20000);
        tx_sof = 1'b1; tx_kind = 1'b1;
        @(negedge clk);
        tx_sof = 1'b0;
        wr(4'd9, 64'd20100);
        reg_addr = 4'd11; #1 check(reg_rdata, 64'd0, "R10 s2m not updated yet");
        @(negedge clk); #1 check(reg_rdata, 64'd400, "R9 s2m delay");
        wr(4'd9, 64'd19000);
        reg_addr = 4'd11;
        @(negedge clk); #1 check(reg_rdata, -64'd700, "R9 negative s2m delay");

        // random phase against the model
        for (int n = 0; n < 3000; n++) begin
            automatic int op = int'($urandom % 8);
            tx_sof = ($urandom % 3) == 0; tx_kind = 1'($urandom);
            rx_sof = ($urandom % 3) == 0; rx_kind = 1'($urandom);
            reg_we = 1'b0; reg_re = 1'b0;
            case (op)
                0: begin reg_we = 1'b1; reg_addr = 4'd6; reg_wdata = {$urandom, $urandom}; end
                1: begin reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = {32'd0, $urandom}; end
                2: begin reg_we = 1'b1; reg_addr = 4'd9; reg_wdata = {32'd0, $urandom}; end
                3: begin reg_we = 1'b1; reg_addr = 4'd7; reg_wdata = {$urandom, $urandom}; end
                default: begin reg_re = 1'($urandom); reg_addr = 4'($urandom % 13); end
            endcase
            #1 check(reg_rdata, model_read(reg_addr), "R4 R5 R6 R8 R9 random vs model");
            @(negedge clk);
        end
        tx_sof = 1'b0; rx_sof = 1'b0; reg_we = 1'b0; reg_re = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule